// File: doc/BRIEF.md
# Texture Unit Residency Tracker

This block keeps a residency verdict for each of a set of texture units (eight by default). Each unit owns two cache banks, even and odd. For each bank the block stores a width code, a height code, a base address and a byte size. Configuration writes load bank geometry. Any configuration write addressed to a unit throws that unit's verdict back to INVALID.

A bind command names a unit and gives the texture's dimensions plus two flags, mipmapped and 32-bit. On a bind the block decodes the bank capacities from the exponent codes and tests whether the texture fits. It then records the unit as CACHED when the texture fits and as VALID when it does not. An invalidate command drops every unit to INVALID at once.

Per-unit valid and cached vectors report the verdicts. A query port shows the stored base and size of both banks of one selected unit.

Top module: `tex_res_tracker`

## Requirements
- R1: After reset every unit is INVALID, so `unit_valid` and `unit_cached` are all zero. Every stored base and size reads zero.
- R2: A configuration write with `cfg_sel` of 0 or 3 marks the addressed unit INVALID and leaves its bank geometry and sizes unchanged.
- R3: With `cfg_sel`=1 a configuration write loads the even bank of the addressed unit. With `cfg_sel`=2 it loads the odd bank. The bank takes the width and height codes, a base equal to `cfg_offset` shifted left by 5, and a size of zero. The unit becomes INVALID.
- R4: Bank capacity is decoded from width code w and height code h. When w equals h and is 3, 4 or 5, the capacity is 32768, 131072 or 524288 bytes. Otherwise it is 512 x 2^w x 2^h, computed without wrap for every code up to 15.
- R5: On a bind, the even bank capacity is recomputed. The texture needs width x height x 32 bytes and fits the even bank when that need is at most the capacity (equality fits). The unit becomes CACHED if the texture fits and VALID otherwise. A cached unit always also reads valid.
- R6: When a bind has the mipmapped flag or the 32-bit flag set, the odd capacity is recomputed and the need must also be at most that capacity. With neither flag set, the odd size becomes zero and the odd bank plays no part in the fit.
- R7: After the fit test, a mipmapped bind stores twice the even capacity. A bind that is both mipmapped and 32-bit also stores twice the odd capacity. A bind that is 32-bit only stores the odd capacity undoubled.
- R8: An invalidate command makes every unit INVALID. It leaves all geometry and sizes unchanged, and its parameter has no effect.
- R9: When commands coincide, the following order applies. An invalidate wins over a bind in the same cycle, and that bind leaves the sizes unchanged. A configuration write to the unit being bound wins, and that bind has no effect. A bind to any other unit still applies.
- R10: Every command's effect is visible on the outputs in the cycle after the clock edge that samples it. The query outputs follow `qry_unit` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_unit | input | 3 | Unit addressed by the write |
| cfg_sel | input | 2 | 1 even geometry, 2 odd geometry, 0/3 other register |
| cfg_wcode | input | 4 | Bank width exponent code |
| cfg_hcode | input | 4 | Bank height exponent code |
| cfg_offset | input | 16 | Bank offset field (base = offset << 5) |
| inv_valid | input | 1 | Invalidate-all strobe |
| inv_param | input | 32 | Invalidate parameter, ignored |
| bind_valid | input | 1 | Bind strobe |
| bind_unit | input | 3 | Unit being bound |
| bind_width | input | 12 | Texture width |
| bind_height | input | 12 | Texture height |
| bind_mip | input | 1 | Texture is mipmapped |
| bind_w32 | input | 1 | Texture is 32-bit |
| qry_unit | input | 3 | Unit shown on the query outputs |
| unit_valid | output | 8 | Per-unit: state is not INVALID |
| unit_cached | output | 8 | Per-unit: state is CACHED |
| qry_even_base | output | 21 | Even bank base of the queried unit |
| qry_even_size | output | 41 | Even bank size of the queried unit |
| qry_odd_base | output | 21 | Odd bank base of the queried unit |
| qry_odd_size | output | 41 | Odd bank size of the queried unit |

## Verification
Every command lands in the unit registers at the clock edge that samples it. Its result is therefore due one cycle later on `unit_valid`, `unit_cached` and the query outputs. The query outputs additionally follow `qry_unit` with no delay.

The bench drives inputs just after a falling edge and advances its behavioural model at the rising edge. It compares all outputs at the following falling edge, so every comparison lands exactly one register stage after its stimulus. The stimulus includes the fit boundary (need equal to capacity), the decode special cases, the largest codes, and coinciding commands.

// File: rtl/tex_res_pkg.sv
package tex_res_pkg;

    localparam int CODE_W = 4;
    localparam int OFS_W  = 16;
    localparam int BASE_W = OFS_W + 5;
    // largest capacity is 512 * 2^(2*max code); one more bit holds its double
    localparam int SZ_W   = 9 + 2 * ((1 << CODE_W) - 1) + 2;

    typedef enum logic [1:0] {
        ST_INVALID = 2'b00,
        ST_VALID   = 2'b01,
        ST_CACHED  = 2'b11
    } res_state_e;

    typedef enum logic [1:0] {
        SEL_OTHER = 2'd0,
        SEL_EVEN  = 2'd1,
        SEL_ODD   = 2'd2,
        SEL_MISC  = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [CODE_W-1:0] wcode;
        logic [CODE_W-1:0] hcode;
        logic [BASE_W-1:0] base;
        logic [SZ_W-1:0]   size;
    } bank_t;

    function automatic logic [SZ_W-1:0] bank_bytes(input logic [CODE_W-1:0] w,
                                                   input logic [CODE_W-1:0] h);
        logic [CODE_W:0] sh;
        sh = {1'b0, w} + {1'b0, h};
        if (w == h && w == CODE_W'(3)) return SZ_W'(32768);
        if (w == h && w == CODE_W'(4)) return SZ_W'(131072);
        if (w == h && w == CODE_W'(5)) return SZ_W'(524288);
        return SZ_W'(512) << sh;
    endfunction

endpackage

// File: rtl/tex_res_size_dec.sv
module tex_res_size_dec
    import tex_res_pkg::*;
(
    input  logic [CODE_W-1:0] wcode,
    input  logic [CODE_W-1:0] hcode,
    output logic [SZ_W-1:0]   capacity
);
    always_comb capacity = bank_bytes(wcode, hcode);
endmodule

// File: rtl/tex_res_fit.sv
module tex_res_fit
    import tex_res_pkg::*;
#(
    parameter int DIM_W = 12
) (
    input  logic [DIM_W-1:0] width,
    input  logic [DIM_W-1:0] height,
    input  logic             mip,
    input  logic             w32,
    input  logic [SZ_W-1:0]  even_cap,
    input  logic [SZ_W-1:0]  odd_cap,
    output logic             fits,
    output logic [SZ_W-1:0]  even_size,
    output logic [SZ_W-1:0]  odd_size
);
    logic [SZ_W-1:0] need;
    logic            odd_used;

    always_comb begin
        need      = (SZ_W'(width) * SZ_W'(height)) << 5;
        odd_used  = mip | w32;
        fits      = (need <= even_cap) && (!odd_used || (need <= odd_cap));
        even_size = mip ? (even_cap << 1) : even_cap;
        if (!odd_used)
            odd_size = '0;
        else if (mip && w32)
            odd_size = odd_cap << 1;
        else
            odd_size = odd_cap;
    end
endmodule

// File: rtl/tex_res_unit.sv
module tex_res_unit
    import tex_res_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              inv_all,
    input  logic              cfg_hit,
    input  cfg_sel_e          cfg_sel,
    input  logic [CODE_W-1:0] cfg_wcode,
    input  logic [CODE_W-1:0] cfg_hcode,
    input  logic [OFS_W-1:0]  cfg_offset,
    input  logic              bind_hit,
    input  logic              bind_fits,
    input  logic [SZ_W-1:0]   bind_even_size,
    input  logic [SZ_W-1:0]   bind_odd_size,
    output bank_t             even_bank,
    output bank_t             odd_bank,
    output res_state_e        state
);
    bank_t loaded;

    always_comb begin
        loaded.wcode = cfg_wcode;
        loaded.hcode = cfg_hcode;
        loaded.base  = BASE_W'(cfg_offset) << 5;
        loaded.size  = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_INVALID;
            even_bank <= '0;
            odd_bank  <= '0;
        end else begin
            if (cfg_hit) begin
                state <= ST_INVALID;
                if (cfg_sel == SEL_EVEN) even_bank <= loaded;
                if (cfg_sel == SEL_ODD)  odd_bank  <= loaded;
            end else if (bind_hit && !inv_all) begin
                state          <= bind_fits ? ST_CACHED : ST_VALID;
                even_bank.size <= bind_even_size;
                odd_bank.size  <= bind_odd_size;
            end
            if (inv_all) state <= ST_INVALID;
        end
    end
endmodule

// File: rtl/tex_res_tracker.sv
module tex_res_tracker
    import tex_res_pkg::*;
#(
    parameter int NUM_UNITS = 8,
    parameter int DIM_W     = 12,
    parameter int PARAM_W   = 32,
    localparam int UIDX_W   = $clog2(NUM_UNITS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_valid,
    input  logic [UIDX_W-1:0]    cfg_unit,
    input  logic [1:0]           cfg_sel,
    input  logic [CODE_W-1:0]    cfg_wcode,
    input  logic [CODE_W-1:0]    cfg_hcode,
    input  logic [OFS_W-1:0]     cfg_offset,
    input  logic                 inv_valid,
    input  logic [PARAM_W-1:0]   inv_param,
    input  logic                 bind_valid,
    input  logic [UIDX_W-1:0]    bind_unit,
    input  logic [DIM_W-1:0]     bind_width,
    input  logic [DIM_W-1:0]     bind_height,
    input  logic                 bind_mip,
    input  logic                 bind_w32,
    input  logic [UIDX_W-1:0]    qry_unit,
    output logic [NUM_UNITS-1:0] unit_valid,
    output logic [NUM_UNITS-1:0] unit_cached,
    output logic [BASE_W-1:0]    qry_even_base,
    output logic [SZ_W-1:0]      qry_even_size,
    output logic [BASE_W-1:0]    qry_odd_base,
    output logic [SZ_W-1:0]      qry_odd_size
);
    bank_t      even_q [NUM_UNITS];
    bank_t      odd_q  [NUM_UNITS];
    res_state_e st_q   [NUM_UNITS];

    logic [SZ_W-1:0] even_cap, odd_cap, new_even, new_odd;
    logic            fits;
    logic            param_unused;
    cfg_sel_e        sel;

    assign param_unused = ^inv_param;   // parameter carries no meaning here
    assign sel          = cfg_sel_e'(cfg_sel);

    tex_res_size_dec even_dec_i (
        .wcode(even_q[bind_unit].wcode), .hcode(even_q[bind_unit].hcode), .capacity(even_cap));
    tex_res_size_dec odd_dec_i (
        .wcode(odd_q[bind_unit].wcode), .hcode(odd_q[bind_unit].hcode), .capacity(odd_cap));

    tex_res_fit #(.DIM_W(DIM_W)) fit_i (
        .width(bind_width), .height(bind_height), .mip(bind_mip), .w32(bind_w32),
        .even_cap(even_cap), .odd_cap(odd_cap),
        .fits(fits), .even_size(new_even), .odd_size(new_odd));

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        tex_res_unit unit_i (
            .clk(clk), .rst(rst), .inv_all(inv_valid),
            .cfg_hit(cfg_valid && cfg_unit == UIDX_W'(u)), .cfg_sel(sel),
            .cfg_wcode(cfg_wcode), .cfg_hcode(cfg_hcode), .cfg_offset(cfg_offset),
            .bind_hit(bind_valid && bind_unit == UIDX_W'(u)), .bind_fits(fits),
            .bind_even_size(new_even), .bind_odd_size(new_odd),
            .even_bank(even_q[u]), .odd_bank(odd_q[u]), .state(st_q[u]));
        assign unit_valid[u]  = st_q[u] != ST_INVALID;
        assign unit_cached[u] = st_q[u] == ST_CACHED;
    end

    always_comb begin
        qry_even_base = even_q[qry_unit].base;
        qry_even_size = even_q[qry_unit].size;
        qry_odd_base  = odd_q[qry_unit].base;
        qry_odd_size  = odd_q[qry_unit].size;
    end
endmodule

// File: rtl/tex_res_tracker_chk.sv
module tex_res_tracker_chk
    import tex_res_pkg::*;
#(
    parameter int NUM_UNITS = 8,
    parameter int DIM_W     = 12,
    localparam int UIDX_W   = $clog2(NUM_UNITS)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cfg_valid,
    input logic [UIDX_W-1:0]    cfg_unit,
    input logic [1:0]           cfg_sel,
    input logic [OFS_W-1:0]     cfg_offset,
    input logic                 inv_valid,
    input logic                 bind_valid,
    input logic [UIDX_W-1:0]    bind_unit,
    input logic                 bind_mip,
    input logic                 bind_w32,
    input logic [UIDX_W-1:0]    qry_unit,
    input logic [NUM_UNITS-1:0] unit_valid,
    input logic [NUM_UNITS-1:0] unit_cached,
    input logic [BASE_W-1:0]    qry_even_base,
    input logic [SZ_W-1:0]      qry_even_size,
    input logic [SZ_W-1:0]      qry_odd_size
);
    p_cached_is_valid_r5: assert property (@(posedge clk) disable iff (rst)
        (unit_cached & ~unit_valid) == '0);

    p_cfg_invalidates_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_valid |=> !unit_valid[$past(cfg_unit)]);

    p_inv_clears_all_r8: assert property (@(posedge clk) disable iff (rst)
        inv_valid |=> unit_valid == '0);

    p_bind_lands_r10: assert property (@(posedge clk) disable iff (rst)
        (bind_valid && !inv_valid && !(cfg_valid && cfg_unit == bind_unit))
        |=> unit_valid[$past(bind_unit)]);

    p_even_load_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid && cfg_sel == 2'd1 && cfg_unit == qry_unit)
        |=> (qry_unit != $past(qry_unit)) ||
            (qry_even_size == '0 && qry_even_base == (BASE_W'($past(cfg_offset)) << 5)));

    p_odd_unused_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (bind_valid && !bind_mip && !bind_w32 && !inv_valid &&
         !(cfg_valid && cfg_unit == bind_unit) && bind_unit == qry_unit)
        |=> (qry_unit != $past(qry_unit)) || qry_odd_size == '0);
endmodule

bind tex_res_tracker tex_res_tracker_chk #(.NUM_UNITS(NUM_UNITS), .DIM_W(DIM_W)) chk_i (.*);

// File: tb/tex_res_tracker_tb_top.sv
module tex_res_tracker_tb_top;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_valid;
    logic [2:0]  cfg_unit;
    logic [1:0]  cfg_sel;
    logic [3:0]  cfg_wcode, cfg_hcode;
    logic [15:0] cfg_offset;
    logic        inv_valid;
    logic [31:0] inv_param;
    logic        bind_valid;
    logic [2:0]  bind_unit;
    logic [11:0] bind_width, bind_height;
    logic        bind_mip, bind_w32;
    logic [2:0]  qry_unit;
    logic [N-1:0] unit_valid, unit_cached;
    logic [20:0] qry_even_base, qry_odd_base;
    logic [40:0] qry_even_size, qry_odd_size;

    always #4 clk = ~clk;   // 125 MHz

    tex_res_tracker dut_i (.*);

    // reference model
    int     m_st [N];          // 0 invalid, 1 valid, 2 cached
    int     m_ew [N], m_eh [N], m_ow [N], m_oh [N];
    longint m_eb [N], m_ob [N], m_es [N], m_os [N];

    int    n_checks = 0;
    int    n_fail   = 0;
    string phase    = "R1";
    int    seed     = 12345;

    function automatic longint cap(int w, int h);
        if (w == h && w == 3) return 32768;
        if (w == h && w == 4) return 131072;
        if (w == h && w == 5) return 524288;
        return longint'(512) << (w + h);
    endfunction

    task automatic model_reset();
        for (int u = 0; u < N; u++) begin
            m_st[u] = 0; m_ew[u] = 0; m_eh[u] = 0; m_ow[u] = 0; m_oh[u] = 0;
            m_eb[u] = 0; m_ob[u] = 0; m_es[u] = 0; m_os[u] = 0;
        end
    endtask

    task automatic model_step();
        longint need, ec, oc;
        bit fit;
        if (rst) begin model_reset(); return; end
        if (bind_valid && !inv_valid && !(cfg_valid && cfg_unit == bind_unit)) begin
            need = longint'(bind_width) * longint'(bind_height) * 32;
            ec   = cap(m_ew[bind_unit], m_eh[bind_unit]);
            oc   = cap(m_ow[bind_unit], m_oh[bind_unit]);
            fit  = need <= ec;
            if (bind_mip || bind_w32) fit = fit && (need <= oc);
            m_st[bind_unit] = fit ? 2 : 1;
            m_es[bind_unit] = bind_mip ? 2 * ec : ec;
            m_os[bind_unit] = !(bind_mip || bind_w32) ? 0 : ((bind_mip && bind_w32) ? 2 * oc : oc);
        end
        if (cfg_valid) begin
            m_st[cfg_unit] = 0;
            if (cfg_sel == 2'd1) begin
                m_ew[cfg_unit] = cfg_wcode; m_eh[cfg_unit] = cfg_hcode;
                m_eb[cfg_unit] = longint'(cfg_offset) * 32; m_es[cfg_unit] = 0;
            end
            if (cfg_sel == 2'd2) begin
                m_ow[cfg_unit] = cfg_wcode; m_oh[cfg_unit] = cfg_hcode;
                m_ob[cfg_unit] = longint'(cfg_offset) * 32; m_os[cfg_unit] = 0;
            end
        end
        if (inv_valid) for (int u = 0; u < N; u++) m_st[u] = 0;
    endtask

    task automatic check(string what, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", phase, what, act, exp);
        end
    endtask

    task automatic compare();
        logic [N-1:0] ev, ec;
        for (int u = 0; u < N; u++) begin
            ev[u] = m_st[u] != 0;
            ec[u] = m_st[u] == 2;
        end
        check("unit_valid", longint'(unit_valid), longint'(ev));
        check("unit_cached", longint'(unit_cached), longint'(ec));
        check("even_base", longint'(qry_even_base), m_eb[qry_unit]);
        check("even_size", longint'(qry_even_size), m_es[qry_unit]);
        check("odd_base", longint'(qry_odd_base), m_ob[qry_unit]);
        check("odd_size", longint'(qry_odd_size), m_os[qry_unit]);
    endtask

    task automatic idle();
        cfg_valid = 0; cfg_unit = 0; cfg_sel = 0; cfg_wcode = 0; cfg_hcode = 0; cfg_offset = 0;
        inv_valid = 0; inv_param = 0;
        bind_valid = 0; bind_unit = 0; bind_width = 0; bind_height = 0;
        bind_mip = 0; bind_w32 = 0;
    endtask

    // one cycle: inputs already driven; model at rising edge, compare at falling edge
    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        idle();
    endtask

    task automatic cfg(int u, int sel, int w, int h, int ofs);
        cfg_valid = 1; cfg_unit = 3'(u); cfg_sel = 2'(sel);
        cfg_wcode = 4'(w); cfg_hcode = 4'(h); cfg_offset = 16'(ofs);
        qry_unit = 3'(u);
        tick();
    endtask

    task automatic bnd(int u, int w, int h, bit mip, bit w32);
        bind_valid = 1; bind_unit = 3'(u); bind_width = 12'(w); bind_height = 12'(h);
        bind_mip = mip; bind_w32 = w32; qry_unit = 3'(u);
        tick();
    endtask

    function automatic int lcg();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 8) & 32'h7fffff;
    endfunction

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        idle(); qry_unit = 0; rst = 1; model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        phase = "R1"; tick();

        phase = "R3";
        cfg(0, 1, 3, 3, 16'h10);
        cfg(0, 2, 4, 3, 16'h200);
        phase = "R5";
        bnd(0, 32, 32, 0, 0);      // need 32768 = capacity: fits
        bnd(0, 32, 33, 0, 0);      // one row over: valid only
        phase = "R6";
        bnd(0, 32, 32, 0, 1);      // odd 65536 fits
        cfg(0, 2, 2, 2, 16'h300);  // odd 8192
        bnd(0, 32, 32, 0, 1);      // odd too small
        bnd(0, 32, 32, 0, 0);      // odd ignored, size zero
        phase = "R7";
        cfg(0, 2, 4, 4, 16'h300);
        bnd(0, 16, 16, 1, 0);
        bnd(0, 16, 16, 1, 1);
        bnd(0, 16, 16, 0, 1);
        phase = "R4";
        cfg(1, 1, 15, 15, 16'hffff);
        cfg(1, 2, 4, 5, 1);
        bnd(1, 4095, 4095, 1, 1);
        cfg(2, 1, 0, 0, 0);
        cfg(2, 2, 5, 5, 7);
        bnd(2, 4, 4, 0, 1);
        bnd(2, 4, 5, 0, 1);
        phase = "R2";
        bnd(3, 1, 1, 0, 0);
        cfg(3, 0, 9, 9, 99);
        bnd(1, 2, 2, 0, 0);
        cfg(1, 3, 9, 9, 99);
        phase = "R8";
        bnd(4, 1, 1, 0, 0);
        bnd(5, 1, 1, 0, 0);
        inv_valid = 1; inv_param = 32'hdeadbeef; qry_unit = 4; tick();
        phase = "R9";
        bnd(6, 1, 1, 0, 0);
        inv_valid = 1; bind_valid = 1; bind_unit = 7; bind_width = 1; bind_height = 1;
        bind_mip = 1; qry_unit = 7; tick();
        cfg_valid = 1; cfg_unit = 7; cfg_sel = 1; cfg_wcode = 6; cfg_hcode = 6; cfg_offset = 5;
        bind_valid = 1; bind_unit = 7; bind_width = 1; bind_height = 1; tick();
        cfg_valid = 1; cfg_unit = 6; cfg_sel = 2; cfg_wcode = 1; cfg_hcode = 1;
        bind_valid = 1; bind_unit = 7; bind_width = 8; bind_height = 8; bind_mip = 1; tick();

        phase = "R10";
        for (int i = 0; i < 600; i++) begin
            int r;
            r = lcg();
            cfg_valid  = (r % 5) == 0;
            cfg_unit   = 3'(lcg()); cfg_sel = 2'(lcg());
            cfg_wcode  = 4'(lcg() % 8); cfg_hcode = 4'(lcg() % 8); cfg_offset = 16'(lcg());
            inv_valid  = (lcg() % 23) == 0; inv_param = 32'(lcg());
            bind_valid = (lcg() % 2) == 0; bind_unit = 3'(lcg());
            bind_width = 12'(lcg() % 300); bind_height = 12'(lcg() % 300);
            bind_mip   = lcg()[0]; bind_w32 = lcg()[0];
            qry_unit   = 3'(lcg());
            tick();
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule